// File: doc/BRIEF.md
# Mode-Configurable Clock-Crossing FIFO

This block is a dual-clock FIFO. It moves words from a producer clock domain to a consumer clock domain. A typical use is carrying commands, write data or read data between a bus port and a memory core. The write side and the read side each have their own clock, their own active-low reset and a valid/ready handshake. A local full flag sits on the write side and a local empty flag on the read side. The read side is show-ahead: whenever a word is waiting, the oldest one is already on `rd_data`.

Both pointers are gray-coded and carry one wrap bit. Each pointer crosses into the other domain through a synchronizer whose depth is set at run time by a static two-bit clock-relationship input:

| Code | Clock relationship | Synchronizer depth |
|------|--------------------|--------------------|
| `2'b00` | Unrelated clocks | two stages |
| `2'b01` | Phase-aligned, write port at half the read-side rate | one stage |
| `2'b10` | Phase-aligned, write port at double the read-side rate | one stage |
| `2'b11` | Reserved; handled as `2'b00` | two stages |

The mode may be changed only while both resets are held. With one stage, each crossing is one destination-clock cycle shorter.

Top module: `mode_sync_fifo`

## Requirements
- R1: While and after both resets, rd_empty=1, rd_valid=0, wr_full=0 and wr_ready=1.
- R2: Every accepted word is read out exactly once, in the order it was written, for every mode and for write/read clock ratios of 1:1, 1:2 and 2:1.
- R3: With no reads, wr_full rises right after the clock edge that accepts the DEPTH-th word (8 by default) and not before. wr_ready is always the inverse of wr_full.
- R4: A write attempted while wr_full=1 is dropped. The write pointer does not move, and the stored contents read back unchanged.
- R5: A read attempted while rd_empty=1 is dropped. The read pointer does not move. rd_valid is always the inverse of rd_empty.
- R6: With clk_mode=2'b00 and edge-aligned clocks, two things hold. rd_empty falls after the second read-clock rising edge that follows the write-clock edge accepting a word into an empty FIFO. wr_full falls after the second write-clock rising edge that follows the read-clock edge popping from a full FIFO. clk_mode holds steady while the write side is out of reset.
- R7: With clk_mode=2'b01 or 2'b10, both of those delays shrink to the first following rising edge.
- R8: clk_mode=2'b11 gives exactly the 2'b00 timing.
- R9: Whenever rd_valid=1, rd_data shows the oldest unread word before that word is popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset, active low, asynchronous |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | DW | Word to store |
| wr_ready | output | 1 | FIFO can take a word |
| wr_full | output | 1 | All DEPTH slots hold words, as seen from the write side |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side reset, active low, asynchronous |
| rd_valid | output | 1 | A word is available |
| rd_data | output | DW | Oldest unread word |
| rd_ready | input | 1 | Consumer takes the word |
| rd_empty | output | 1 | No word is visible on the read side |
| clk_mode | input | 2 | Clock relationship: 00 unrelated, 01 port half rate, 10 port double rate, 11 treated as 00 |

## Verification
A local flag reacts at once.
- wr_full, wr_ready, rd_empty and rd_valid change right after the clock edge in their own domain that moves the local pointer.
- The bench therefore samples them at the next falling edge of that clock.

A remote flag is due one or two destination rising edges after the source edge, depending on the mode.
- The latency scenarios run both clocks edge-aligned at 200 MHz.
- They sample at each following falling edge of the destination clock, so each expected value falls between two known edges.

Ordering checks happen in edge monitors. These record each handshake at the same edge the design acts on, and compare the popped word against a queue filled from accepted writes.

// File: rtl/msf_pkg.sv
`timescale 1ns/1ps
package msf_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC       = 2'b00,
        MODE_PORT_HALF   = 2'b01,
        MODE_PORT_DOUBLE = 2'b10,
        MODE_RESERVED    = 2'b11
    } clk_mode_e;

    // A single synchronizer stage is legal only for the phase-aligned ratios;
    // every other code, including the reserved one, keeps both stages.
    function automatic logic one_stage_sel(input logic [1:0] m);
        clk_mode_e em;
        em = clk_mode_e'(m);
        return (em == MODE_PORT_HALF) || (em == MODE_PORT_DOUBLE);
    endfunction

endpackage

// File: rtl/msf_ptr_sync.sv
`timescale 1ns/1ps
module msf_ptr_sync #(
    parameter int W = 4
) (
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    input  logic         one_stage,
    input  logic [W-1:0] src_gray,
    output logic [W-1:0] dst_gray
);

    logic [W-1:0] stg1;
    logic [W-1:0] stg2;

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            stg1 <= '0;
            stg2 <= '0;
        end else begin
            stg1 <= src_gray;
            stg2 <= stg1;
        end
    end

    assign dst_gray = one_stage ? stg1 : stg2;

endmodule

// File: rtl/msf_wr_ctl.sv
`timescale 1ns/1ps
module msf_wr_ctl #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [AW:0]   rq_gray,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          full,
    output logic          push
);

    localparam int PW = AW + 1;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;

    // Full: same slot index, opposite lap; in gray form the top two bits differ.
    assign full    = (wgray == {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]});
    assign push    = push_req & ~full;
    assign wbin_nx = wbin + PW'(1);
    assign waddr   = wbin[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> (wgray == $past(wgray)));                        // R4
    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);                                 // R2

endmodule

// File: rtl/msf_rd_ctl.sv
`timescale 1ns/1ps
module msf_rd_ctl #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req,
    input  logic [AW:0]   wq_gray,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          empty,
    output logic          pop
);

    localparam int            PW     = AW + 1;
    localparam logic [PW-1:0] SLOTS  = PW'(1 << AW);

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    assign empty   = (rgray == wq_gray);
    assign pop     = pop_req & ~empty;
    assign rbin_nx = rbin + PW'(1);
    assign raddr   = rbin[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> (rgray == $past(rgray)));                        // R5
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (g2b(wq_gray) - rbin) <= SLOTS);                                        // R3
    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);                                 // R2

endmodule

// File: rtl/msf_store.sv
`timescale 1ns/1ps
module msf_store #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int SLOTS = 1 << AW;

    logic [DW-1:0] mem [SLOTS];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mode_sync_fifo.sv
`timescale 1ns/1ps
module mode_sync_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic          wr_full,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          rd_ready,
    output logic          rd_empty,
    input  logic [1:0]    clk_mode
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          one_stage;
    logic [PW-1:0] wgray, rgray, wq_gray, rq_gray;
    logic [AW-1:0] waddr, raddr;
    logic          push, pop;

    assign one_stage = msf_pkg::one_stage_sel(clk_mode);

    msf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .push_req(wr_valid), .rq_gray(rq_gray),
        .wgray(wgray), .waddr(waddr), .full(wr_full), .push(push)
    );

    msf_rd_ctl #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .pop_req(rd_ready), .wq_gray(wq_gray),
        .rgray(rgray), .raddr(raddr), .empty(rd_empty), .pop(pop)
    );

    msf_ptr_sync #(.W(PW)) u_w2r (
        .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .one_stage(one_stage),
        .src_gray(wgray), .dst_gray(wq_gray)
    );

    msf_ptr_sync #(.W(PW)) u_r2w (
        .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .one_stage(one_stage),
        .src_gray(rgray), .dst_gray(rq_gray)
    );

    msf_store #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rd_data)
    );

    assign wr_ready = ~wr_full;
    assign rd_valid = ~rd_empty;

    AST_MODE_STATIC: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $stable(clk_mode));                                                     // R6
    AST_POP_NEEDS_DATA: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        pop |-> rd_valid);                                                      // R5
    AST_PUSH_NEEDS_ROOM: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        push |-> wr_ready);                                                     // R4

endmodule

// File: tb/tb_mode_sync_fifo.sv
`timescale 1ns/1ps
module tb_mode_sync_fifo;

    logic       wr_clk, rd_clk;
    logic       wr_rst_n, rd_rst_n;
    logic       wr_valid, rd_ready;
    logic [7:0] wr_data;
    logic       wr_ready, wr_full, rd_valid, rd_empty;
    logic [7:0] rd_data;
    logic [1:0] clk_mode;

    int         tick;
    int         rel_sel;
    int         n_chk, n_fail;
    int         wr_cnt, rd_cnt;
    logic [7:0] exp_q[$];

    mode_sync_fifo #(.DW(8), .DEPTH(8)) dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_full(wr_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_ready(rd_ready), .rd_empty(rd_empty), .clk_mode(clk_mode)
    );

    // One tick is half a 200 MHz period; the slow clock is edge-aligned with the fast one.
    initial tick = 0;
    always #2.5 tick = tick + 1;

    always_comb begin
        logic fast, slow;
        fast = tick[0];
        slow = ((tick + 1) >> 1) % 2 == 1;
        unique case (rel_sel)
            1:       begin wr_clk = slow; rd_clk = fast; end
            2:       begin wr_clk = fast; rd_clk = slow; end
            default: begin wr_clk = fast; rd_clk = fast; end
        endcase
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitors act on the same edge as the design, on pre-edge values.
    always @(posedge wr_clk) begin
        if (wr_rst_n && wr_valid && wr_ready) begin
            exp_q.push_back(wr_data);
            wr_cnt++;
        end
    end

    always @(posedge rd_clk) begin
        if (rd_rst_n && rd_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 pop without write", rd_data, -1);
            end else begin
                chk(rd_data == exp_q[0], "R2/R9 order", rd_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
            rd_cnt++;
        end
    end

    task automatic do_reset(input logic [1:0] mode, input int rel);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        wr_valid = 1'b0;
        rd_ready = 1'b0;
        wr_data  = '0;
        clk_mode = mode;
        rel_sel  = rel;
        exp_q.delete();
        #20;
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
    endtask

    task automatic push(input logic [7:0] d);
        int tgt;
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_data  = d;
        tgt = wr_cnt + 1;
        while (wr_cnt < tgt) @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    task automatic pop_one();
        int tgt;
        @(negedge rd_clk);
        rd_ready = 1'b1;
        tgt = rd_cnt + 1;
        while (rd_cnt < tgt) @(negedge rd_clk);
        rd_ready = 1'b0;
    endtask

    task automatic drain(input string req);
        @(negedge rd_clk);
        rd_ready = 1'b1;
        while (exp_q.size() != 0) @(negedge rd_clk);
        repeat (3) @(negedge rd_clk);
        rd_ready = 1'b0;
        chk(rd_empty == 1'b1, req, rd_empty, 1);
    endtask

    task automatic t_reset();
        do_reset(2'b00, 0);
        chk(rd_empty == 1'b1, "R1 rd_empty", rd_empty, 1);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(wr_full  == 1'b0, "R1 wr_full",  wr_full,  0);
        chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    endtask

    // Edge-aligned equal clocks; stages = expected synchronizer depth.
    task automatic t_latency(input logic [1:0] mode, input int stages, input string req);
        do_reset(mode, 0);
        push(8'hA5);
        chk(rd_empty == 1'b1, req, rd_empty, 1);
        @(negedge rd_clk);
        chk(rd_empty == (stages == 2), req, rd_empty, (stages == 2) ? 1 : 0);
        @(negedge rd_clk);
        chk(rd_empty == 1'b0, req, rd_empty, 0);
        chk(rd_data == 8'hA5, "R9 show-ahead", rd_data, 8'hA5);
        for (int i = 1; i < 8; i++) begin
            push(8'(8'hA5 + i));
            if (i == 6) chk(wr_full == 1'b0, "R3 not full at 7", wr_full, 0);
        end
        chk(wr_full == 1'b1, "R3 full at 8", wr_full, 1);
        chk(wr_ready == 1'b0, "R3 ready low", wr_ready, 0);
        pop_one();
        chk(wr_full == 1'b1, req, wr_full, 1);
        @(negedge wr_clk);
        chk(wr_full == (stages == 2), req, wr_full, (stages == 2) ? 1 : 0);
        @(negedge wr_clk);
        chk(wr_full == 1'b0, req, wr_full, 0);
        drain(req);
    endtask

    task automatic t_full_ignore();
        int base_w, base_r;
        do_reset(2'b00, 0);
        for (int i = 0; i < 8; i++) push(8'(8'h10 + i));
        base_w = wr_cnt;
        base_r = rd_cnt;
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_data  = 8'hEE;
        repeat (4) @(negedge wr_clk);
        wr_valid = 1'b0;
        chk(wr_cnt == base_w, "R4 no accept when full", wr_cnt - base_w, 0);
        chk(wr_full == 1'b1, "R4 still full", wr_full, 1);
        drain("R4 drained");
        chk(rd_cnt - base_r == 8, "R4 exactly 8 words", rd_cnt - base_r, 8);
    endtask

    task automatic t_empty_ignore();
        int base_r;
        do_reset(2'b00, 0);
        base_r = rd_cnt;
        @(negedge rd_clk);
        rd_ready = 1'b1;
        repeat (4) @(negedge rd_clk);
        rd_ready = 1'b0;
        chk(rd_cnt == base_r, "R5 no pop when empty", rd_cnt - base_r, 0);
        chk(rd_valid == 1'b0, "R5 rd_valid low", rd_valid, 0);
        push(8'h3C);
        repeat (4) @(negedge rd_clk);
        chk(rd_valid == 1'b1, "R5 rd_valid high", rd_valid, 1);
        chk(rd_data == 8'h3C, "R5/R9 pointer kept", rd_data, 8'h3C);
        pop_one();
        repeat (2) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R5 empty again", rd_empty, 1);
    endtask

    task automatic t_stream(input logic [1:0] mode, input int rel, input int n, input string req);
        int base_r;
        do_reset(mode, rel);
        base_r = rd_cnt;
        fork
            begin
                for (int i = 0; i < n; i++) push(8'(i * 7 + 3));
            end
            begin
                int c;
                c = 0;
                while (rd_cnt < base_r + n) begin
                    @(negedge rd_clk);
                    rd_ready = (c % 3) != 2;
                    c++;
                end
                rd_ready = 1'b0;
            end
        join
        chk(rd_cnt - base_r == n, req, rd_cnt - base_r, n);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        n_chk = 0; n_fail = 0; wr_cnt = 0; rd_cnt = 0;
        rel_sel = 0; clk_mode = 2'b00;
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        wr_valid = 1'b0; rd_ready = 1'b0; wr_data = '0;
        t_reset();
        t_latency(2'b00, 2, "R6 async latency");
        t_latency(2'b01, 1, "R7 half-rate latency");
        t_latency(2'b10, 1, "R7 double-rate latency");
        t_latency(2'b11, 2, "R8 reserved latency");
        t_full_ignore();
        t_empty_ignore();
        t_stream(2'b00, 0, 24, "R2 async 1:1");
        t_stream(2'b01, 1, 24, "R2 port half rate");
        t_stream(2'b10, 2, 24, "R2 port double rate");
        t_stream(2'b00, 2, 24, "R2 async unequal");
        t_stream(2'b11, 1, 24, "R8 reserved stream");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule